// File: doc/BRIEF.md
# Character serializer with internal loopback

This block turns a stream of 10-bit transmission characters into a serial bit stream running at ten times the character rate. The whole design lives in one bit-clock domain. An external character strobe marks every tenth bit-clock cycle. On that strobe the block takes a new character from a valid/ready input into a holding register. On the same strobe it moves the previously held character into a shift register, so consecutive characters leave back to back with no idle bit between them. The lowest-numbered bit of each character goes out first.

The serial line has a true output and a complementary output. A loopback control reroutes the serial stream to a receive-side output. While loopback is active, the line is parked with the true output high and the complementary output low. With loopback off, the receive-side output stays low and the line carries the stream.

The input cannot stall the line, so back-pressure is limited to timing. Ready is high only in strobe cycles, and a character is accepted only on a cycle where valid and ready are both high. If valid is low in a strobe cycle, a fixed fill character is sent in that slot. The fill character defaults to the comma-bearing synchronisation code 10'h17C.

Top module: `ser_loop_tx`

## Requirements
- R1: While reset is high, and at the first edge after it is asserted, the outputs are line_p=0, line_n=1 and rx_loop_bit=0. Reset also clears the holding and shift registers.
- R2: A character is captured on the rising edge where char_stb=1 and in_valid=1. It is transmitted as the next character on the line.
- R3: Each character is sent least significant bit first: bit 0 first and bit 9 last, one bit per clock.
- R4: If in_valid=0 on a strobe edge, the fill character (default 10'h17C) is sent in that character slot.
- R5: in_ready equals char_stb in every cycle.
- R6: in_valid and in_data are ignored on edges without a strobe. They do not change what is transmitted.
- R7: The shift register reloads on every strobe. Characters follow one another with no gap, and strobes come exactly every 10 cycles.
- R8: Bit 0 of a character captured at strobe edge E appears on the outputs after edge E+11. Bit k appears after edge E+11+k.
- R9: If loop_en=1 at an edge, then after that edge line_p=1, line_n=0, and rx_loop_bit carries the serial bit due at that time.
- R10: If loop_en=0 at an edge, then after that edge line_p carries the serial bit, line_n carries its complement, and rx_loop_bit=0.
- R11: After reset, the first character taken is the one at the first strobe. Until that character's bit 0 is due, the serial stream is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| char_stb | input | 1 | Character strobe, high one cycle in ten |
| in_valid | input | 1 | Input character valid |
| in_data | input | 10 | Input character, bit 0 sent first |
| in_ready | output | 1 | High in strobe cycles, when a character is accepted |
| loop_en | input | 1 | Loopback enable |
| line_p | output | 1 | Serial line, true output |
| line_n | output | 1 | Serial line, complementary output |
| rx_loop_bit | output | 1 | Serial stream routed to the receive side during loopback |

## Verification
A scoreboard predicts every serial bit from the characters accepted at the strobes.

Single-bit characters (only bit 0 set, then only bit 9 set) pin down both the bit order and the exact 11-cycle latency. Alternating patterns 10'h155 and 10'h2AA would expose any slip of one bit or any gap between characters. Strobes with valid low must produce the fill character.

Random valid and data toggling between strobes must leave the stream unchanged. Runs of random characters are sent with loopback off, with loopback on, and with loopback toggling per character, which separates the line path from the receive path.

// File: rtl/ser_pkg.sv
`timescale 1ns/1ps
package ser_pkg;
  typedef enum logic {PATH_LINE = 1'b0, PATH_LOOP = 1'b1} path_e;
  localparam int unsigned DEF_CHAR_W = 10;
  localparam logic [DEF_CHAR_W-1:0] DEF_FILL = 10'h17C;
endpackage

// File: rtl/ser_in_reg.sv
`timescale 1ns/1ps
module ser_in_reg #(
  parameter int unsigned CHAR_W = 10,
  parameter logic [CHAR_W-1:0] FILL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              char_stb,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  output logic [CHAR_W-1:0] hold_word
);
  assign in_ready = char_stb;

  always_ff @(posedge clk) begin
    if (rst) hold_word <= '0;
    else if (char_stb) hold_word <= in_valid ? in_data : FILL;
  end

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (char_stb && in_valid) |=> (hold_word == $past(in_data)));
  assert_fill_R4: assert property (@(posedge clk) disable iff (rst)
    (char_stb && !in_valid) |=> (hold_word == FILL));
  assert_ignore_R6: assert property (@(posedge clk) disable iff (rst)
    !char_stb |=> $stable(hold_word));
endmodule

// File: rtl/ser_shifter.sv
`timescale 1ns/1ps
module ser_shifter #(
  parameter int unsigned CHAR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              char_stb,
  input  logic [CHAR_W-1:0] hold_word,
  output logic              tx_bit
);
  localparam int unsigned CW = $clog2(CHAR_W + 1);

  logic [CHAR_W-1:0] shreg;
  logic [CHAR_W-1:0] shift_next;

  generate
    for (genvar i = 0; i < CHAR_W; i++) begin : g_shift
      if (i == CHAR_W - 1) begin : g_top
        assign shift_next[i] = 1'b0;
      end else begin : g_mid
        assign shift_next[i] = shreg[i+1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else if (char_stb) shreg <= hold_word;
    else shreg <= shift_next;
  end

  assign tx_bit = shreg[0];

  logic [CW-1:0] gap_cnt;
  logic          stb_seen;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt  <= '0;
      stb_seen <= 1'b0;
    end else if (char_stb) begin
      gap_cnt  <= '0;
      stb_seen <= 1'b1;
    end else if (gap_cnt != CW'(CHAR_W)) begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  assert_stb_period_R7: assert property (@(posedge clk) disable iff (rst)
    (char_stb && stb_seen) |-> (gap_cnt == CW'(CHAR_W - 1)));
endmodule

// File: rtl/ser_line_drv.sv
`timescale 1ns/1ps
module ser_line_drv
  import ser_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic loop_en,
  input  logic tx_bit,
  output logic line_p,
  output logic line_n,
  output logic rx_loop_bit
);
  path_e path;
  assign path = loop_en ? PATH_LOOP : PATH_LINE;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_p      <= 1'b0;
      line_n      <= 1'b1;
      rx_loop_bit <= 1'b0;
    end else begin
      case (path)
        PATH_LOOP: begin
          line_p      <= 1'b1;
          line_n      <= 1'b0;
          rx_loop_bit <= tx_bit;
        end
        default: begin
          line_p      <= tx_bit;
          line_n      <= ~tx_bit;
          rx_loop_bit <= 1'b0;
        end
      endcase
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!line_p && line_n && !rx_loop_bit));
  assert_parked_R9: assert property (@(posedge clk) disable iff (rst)
    loop_en |=> (line_p && !line_n));
  assert_rx_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !loop_en |=> !rx_loop_bit);
endmodule

// File: rtl/ser_loop_tx.sv
`timescale 1ns/1ps
module ser_loop_tx
  import ser_pkg::*;
#(
  parameter int unsigned CHAR_W = DEF_CHAR_W,
  parameter logic [CHAR_W-1:0] FILL = DEF_FILL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              char_stb,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  input  logic              loop_en,
  output logic              line_p,
  output logic              line_n,
  output logic              rx_loop_bit
);
  logic [CHAR_W-1:0] hold_word;
  logic              tx_bit;

  ser_in_reg #(.CHAR_W(CHAR_W), .FILL(FILL)) u_in (
    .clk(clk), .rst(rst), .char_stb(char_stb), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .hold_word(hold_word));

  ser_shifter #(.CHAR_W(CHAR_W)) u_shift (
    .clk(clk), .rst(rst), .char_stb(char_stb), .hold_word(hold_word),
    .tx_bit(tx_bit));

  ser_line_drv u_drv (
    .clk(clk), .rst(rst), .loop_en(loop_en), .tx_bit(tx_bit),
    .line_p(line_p), .line_n(line_n), .rx_loop_bit(rx_loop_bit));
endmodule

// File: tb/tb_ser_loop_tx.sv
`timescale 1ns/1ps
module tb_ser_loop_tx;
  localparam int W = 10;
  localparam logic [W-1:0] FILL = 10'h17C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic char_stb = 1'b0, in_valid = 1'b0, loop_en = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ready, line_p, line_n, rx_loop_bit;

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  bit exp_q[$];

  always #2.5 clk = ~clk;

  ser_loop_tx dut (
    .clk(clk), .rst(rst), .char_stb(char_stb), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .loop_en(loop_en),
    .line_p(line_p), .line_n(line_n), .rx_loop_bit(rx_loop_bit));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: one character slot of W cycles, strobe in the first cycle
  task automatic send_char(input bit v, input logic [W-1:0] d, input bit lb);
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      loop_en  = lb;
      char_stb = (i == 0);
      if (i == 0) begin
        logic [W-1:0] e;
        in_valid = v;
        in_data  = d;
        e = v ? d : FILL;
        for (int b = 0; b < W; b++) exp_q.push_back(e[b]);
      end else begin
        // R6: noise between strobes must not reach the line
        in_valid = 1'($urandom);
        in_data  = W'($urandom);
      end
    end
  endtask

  // Monitor
  bit started = 0;
  int cnt = 0;
  always @(posedge clk) begin
    #1;
    if (rst) begin
      started = 0;
      cnt = 0;
      chk(!line_p && line_n && !rx_loop_bit, "R1 reset outputs",
          {line_p, line_n, rx_loop_bit}, 3'b010);
    end else begin
      chk(in_ready == char_stb, "R5 ready follows strobe", in_ready, char_stb);
      if (started) cnt++;
      if (char_stb && !started) begin
        started = 1;
        cnt = 0;
      end
      if (!started || cnt < 11) begin
        // R11: zeros until the first character is due
        chk(line_p == loop_en && line_n == !loop_en && !rx_loop_bit,
            "R11 idle after reset", {line_p, line_n, rx_loop_bit},
            {loop_en, !loop_en, 1'b0});
      end else if (exp_q.size() > 0) begin
        bit e;
        e = exp_q.pop_front();
        if (loop_en)
          chk(line_p && !line_n && rx_loop_bit == e, "R9 R3 R8 loopback bit",
              {line_p, line_n, rx_loop_bit}, {2'b10, e});
        else
          chk(line_p == e && line_n == !e && !rx_loop_bit, "R10 R3 R8 R2 R4 R7 line bit",
              {line_p, line_n, rx_loop_bit}, {e, !e, 1'b0});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R8 R3: single set bit at each end
    send_char(1, 10'h001, 0);
    send_char(1, 10'h000, 0);
    send_char(1, 10'h200, 0);
    // R7: alternating patterns, back to back
    send_char(1, 10'h155, 0);
    send_char(1, 10'h2AA, 0);
    send_char(1, 10'h3FF, 0);
    // R4: fill slots
    send_char(0, 10'h3FF, 0);
    send_char(0, 10'h000, 0);
    // R2: random characters, line path
    for (int k = 0; k < 20; k++) send_char(1, W'($urandom), 0);
    // R9: random characters, loopback path
    for (int k = 0; k < 20; k++) send_char(1, W'($urandom), 1);
    // R9 R10: toggling loopback per slot, with some fills
    for (int k = 0; k < 20; k++) send_char(k % 3 != 0, W'($urandom), k[0]);
    send_char(1, 10'h0F0, 0);
    send_char(1, 10'h00F, 0);
    @(negedge clk);
    char_stb = 0;
    in_valid = 0;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule